// File: doc/BRIEF.md
# Framebuffer Line Pixel Serializer

This block turns a linear monochrome framebuffer into a one-bit video stream. A sync sequencer outside the block marks the frame start, each line start and the active picture window. For each line the block reads 52 consecutive bytes through a synchronous read port. The port takes an address and an enable and returns data one cycle later. The block shifts each byte out as eight pixels, least significant bit first. Each pixel is held for three clocks, so a 24 MHz clock gives 416 pixels in 1248 clocks, or 52 us, per line.

The read pointer starts at 0x0100. It steps by one for every byte fetched and keeps counting across line boundaries, so 304 lines walk through the framebuffer as one linear array. The frame-start strobe puts the pointer back at the base. Each byte after the first is prefetched during the eighth pixel of the byte before it, so pixels follow one another with no gap. The video output is black whenever the window input is low and whenever no line is being drawn.

Top module: `fb_pixel_shifter`

## Requirements
- R1: After reset, `pix_out` and `rd_en` are 0 and `rd_addr` is 0x0100.
- R2: In the cycle where `line_start` is high, `rd_en` is high and `rd_addr` carries the current pointer.
- R3: The pixels of a line begin in the second cycle after the `line_start` cycle. Each byte is emitted bit 0 first through bit 7, and each bit is held for exactly 3 clocks.
- R4: A line has exactly 52 fetches and 416 pixels, which is 1248 clocks. After that, `pix_out` stays 0 until the next `line_start`.
- R5: Each fetch after the first comes 24 clocks after the previous one. It falls in the second clock of the previous byte's bit 7, and the new byte's bit 0 follows directly after bit 7 with no gap.
- R6: Every fetch uses the address of the previous fetch plus one, including the first fetch of a new line.
- R7: A cycle with `frame_start` high sets the pointer to 0x0100, and the next fetch uses that address.
- R8: While `active` is low, `pix_out` is 0. While it is high, `pix_out` shows the pixel due in that cycle.
- R9: A `line_start` in the middle of a line drops the current line and starts a new one at the current pointer, with the timing of R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock (24 MHz nominal) |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | One-cycle strobe that sets the pointer to the base |
| line_start | input | 1 | One-cycle strobe that begins a line |
| active | input | 1 | Picture window; output is black while low |
| rd_en | output | 1 | Framebuffer read request |
| rd_addr | output | 16 | Framebuffer byte address |
| rd_data | input | 8 | Read data, valid one cycle after `rd_en` |
| pix_out | output | 1 | Serial pixel output |

## Verification
A wrong bit or clock counter shows up within one byte time, 24 clocks, as a pixel edge in the wrong cycle or a fetch that falls off the 24-clock grid. A wrong pointer shows at the very next fetch as an address that does not step by one. A byte counter with the wrong limit is seen at the end of the line, as a 53rd fetch or as pixels that continue past clock 1248. The bench compares every cycle of every line against a model of the memory contents, so any of these faults is found in the line where it first happens.

// File: rtl/fb_pixel_shifter.sv
module fb_pixel_shifter #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0100,
  parameter int LINE_BYTES = 52,
  parameter int PIX_CLKS = 3,
  parameter int BYTE_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 frame_start,
  input  logic                 line_start,
  input  logic                 active,
  output logic                 rd_en,
  output logic [ADDR_W-1:0]    rd_addr,
  input  logic [BYTE_BITS-1:0] rd_data,
  output logic                 pix_out
);
  localparam int SUB_W = (PIX_CLKS > 2) ? $clog2(PIX_CLKS) : 1;
  localparam int BIT_W = $clog2(BYTE_BITS);
  localparam int CNT_W = $clog2(LINE_BYTES);

  logic [ADDR_W-1:0]    ptr;
  logic [BYTE_BITS-1:0] sh;
  logic [SUB_W-1:0]     sub;
  logic [BIT_W-1:0]     bitn;
  logic [CNT_W-1:0]     byten;
  logic                 busy, first;

  wire last_sub  = sub == SUB_W'(PIX_CLKS - 1);
  wire last_bit  = bitn == BIT_W'(BYTE_BITS - 1);
  wire more      = byten != CNT_W'(LINE_BYTES - 1);
  wire mid_fetch = busy && last_bit && (sub == SUB_W'(PIX_CLKS - 2)) && more;

  assign rd_en   = line_start | mid_fetch;
  assign rd_addr = ptr;
  assign pix_out = busy & active & sh[0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)           ptr <= BASE_ADDR;
    else if (frame_start) ptr <= BASE_ADDR;
    else if (rd_en)       ptr <= ptr + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; first <= 1'b0; sh <= '0;
      sub <= '0; bitn <= '0; byten <= '0;
    end else if (line_start) begin
      first <= 1'b1; busy <= 1'b0; sh <= '0;
    end else if (first) begin
      first <= 1'b0; busy <= 1'b1; sh <= rd_data;
      sub <= '0; bitn <= '0; byten <= '0;
    end else if (busy) begin
      if (!last_sub) sub <= sub + 1'b1;
      else begin
        sub <= '0;
        if (!last_bit) begin
          bitn <= bitn + 1'b1;
          sh   <= sh >> 1;
        end else begin
          bitn <= '0;
          if (more) begin
            byten <= byten + 1'b1;
            sh    <= rd_data;
          end else begin
            busy <= 1'b0;
            sh   <= '0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/fb_pixel_shifter_chk.sv
module fb_pixel_shifter_chk #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0100
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_start,
  input logic              line_start,
  input logic              active,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              pix_out
);
  p_black_outside_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !pix_out);
  p_line_fetch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    line_start |-> rd_en);
  p_base_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> rd_addr == BASE_ADDR);
  p_addr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !frame_start) |=> rd_addr == $past(rd_addr) + 1'b1);
  p_no_burst_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !line_start) |=> !rd_en);
  p_hold_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_en && !frame_start) |=> $stable(rd_addr));
endmodule

bind fb_pixel_shifter fb_pixel_shifter_chk #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .line_start(line_start),
  .active(active), .rd_en(rd_en), .rd_addr(rd_addr), .pix_out(pix_out)
);

// File: tb/fb_pixel_shifter_tb.sv
`timescale 1ns/1ps
module fb_pixel_shifter_tb;
  localparam logic [15:0] BASE = 16'h0100;
  localparam int NLINES = 8;
  // {reload frame, window mode[2:0], restart offset[11:0]}
  localparam logic [15:0] TBL [NLINES] = '{
    {1'b1, 3'd0, 12'd0},
    {1'b0, 3'd0, 12'd0},
    {1'b0, 3'd1, 12'd0},
    {1'b0, 3'd2, 12'd0},
    {1'b0, 3'd3, 12'd0},
    {1'b1, 3'd0, 12'd100},
    {1'b0, 3'd0, 12'd0},
    {1'b1, 3'd2, 12'd0}
  };

  logic clk = 0, rst_n = 0, frame_start = 0, line_start = 0, active = 0;
  logic rd_en, pix_out;
  logic [15:0] rd_addr;
  logic [7:0] rd_data;
  int checks = 0, fails = 0;
  logic [15:0] exp_addr;

  always #2.5 clk = ~clk;

  fb_pixel_shifter u_dut (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .line_start(line_start),
    .active(active), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .pix_out(pix_out)
  );

  function automatic logic [7:0] pat(input logic [15:0] a);
    logic [7:0] m;
    m = a[7:0] * 8'd29;
    return m ^ a[15:8] ^ 8'hA5;
  endfunction

  always @(posedge clk) if (rd_en) rd_data <= pat(rd_addr);

  task automatic check(input bit ok, input string req, input int act, input int exp_v);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  function automatic bit win(input int mode, input int t);
    case (mode)
      0: return 1'b1;
      1: return 1'b0;
      2: return (t >= 300 && t < 900);
      default: return ((t / 5) % 2) == 0;
    endcase
  endfunction

  task automatic run_line(input bit do_frame, input int mode, input int restart);
    int tstart, n_fetch, e_pix, e_tail, e_tim, e_adr;
    int a_pix, x_pix, a_adr, x_adr;
    logic [15:0] lb;
    bit ex;
    if (do_frame) begin
      @(negedge clk); frame_start = 1;
      @(negedge clk); frame_start = 0;
      exp_addr = BASE;
    end
    tstart = 0; n_fetch = 0; e_pix = 0; e_tail = 0; e_tim = 0; e_adr = 0;
    a_pix = 0; x_pix = 0; a_adr = 0; x_adr = 0;
    lb = exp_addr;
    for (int t = 0; t < 1260 + tstart; t++) begin
      int rel;
      bit ex_rd;
      @(negedge clk);
      line_start = (t == 0) || (restart != 0 && t == restart);
      if (restart != 0 && t == restart) begin
        tstart = t; lb = exp_addr; n_fetch = 0;
      end
      active = win(mode, t);
      #1;
      rel = t - tstart;
      if (rel >= 2 && rel < 1250) begin
        logic [7:0] b;
        b = pat(lb + 16'((rel - 2) / 24));
        ex = active & b[((rel - 2) % 24) / 3];
        if (pix_out !== ex) begin
          if (e_pix == 0) begin a_pix = int'(pix_out); x_pix = int'(ex); end
          e_pix++;
        end
      end else if (rel >= 1250 || restart == 0 || t < restart) begin
        if (pix_out !== 1'b0) e_tail++;
      end
      ex_rd = (rel == 0) || (rel >= 24 && rel <= 1224 && rel % 24 == 0);
      if (rd_en !== ex_rd) e_tim++;
      if (rd_en === 1'b1) begin
        if (rd_addr !== exp_addr) begin
          if (e_adr == 0) begin a_adr = int'(rd_addr); x_adr = int'(exp_addr); end
          e_adr++;
        end
        exp_addr = exp_addr + 16'd1;
        n_fetch++;
      end
    end
    line_start = 0;
    active = 0;
    // R3 R8 R9: pixel stream, LSB first, 3 clocks per bit, gated by window
    check(e_pix == 0, "R3 R8 R9 pixel stream", a_pix, x_pix);
    // R4: black before first pixel and after 1248 pixel clocks
    check(e_tail == 0, "R4 black outside line", e_tail, 0);
    // R2 R5: fetch cycles on the 24-clock grid
    check(e_tim == 0, "R2 R5 fetch timing", e_tim, 0);
    // R6 R7: addresses linear, reloaded on frame start
    check(e_adr == 0, "R6 R7 fetch address", a_adr, x_adr);
    // R4: exactly 52 fetches per line
    check(n_fetch == 52, "R4 fetch count", n_fetch, 52);
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    exp_addr = BASE;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(pix_out === 1'b0, "R1 pix_out in reset", int'(pix_out), 0);
    check(rd_en === 1'b0, "R1 rd_en in reset", int'(rd_en), 0);
    rst_n = 1;
    @(negedge clk); #1;
    check(rd_addr === BASE, "R1 rd_addr after reset", int'(rd_addr), int'(BASE));
    check(pix_out === 1'b0, "R1 idle output", int'(pix_out), 0);
    for (int i = 0; i < NLINES; i++)
      run_line(TBL[i][15], int'(TBL[i][14:12]), int'(TBL[i][11:0]));
    // R7: frame reload with no line following leaves pointer at base
    @(negedge clk); frame_start = 1;
    @(negedge clk); frame_start = 0; #1;
    check(rd_addr === BASE, "R7 reload", int'(rd_addr), int'(BASE));
    // R8: window held high while idle still gives black
    active = 1;
    repeat (5) @(negedge clk);
    #1;
    check(pix_out === 1'b0, "R8 idle black", int'(pix_out), 0);
    active = 0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule